// File: doc/BRIEF.md
# Address-Triggered ROM Bank Mapper

This block sits on the cartridge side of a 21-bit physical address bus and lets a 2 MB ROM appear inside a 1 MB ROM region. The region is the half of the address space where bit 20 is low. The lower 512 KB of the region is hard-wired to the first 512 KB of the ROM. The upper 512 KB is a window onto one of four 512 KB ROM banks.

The window's bank is chosen by a write cycle to one of four trigger addresses. These addresses sit at the start of the slot beginning at 0x001FF0, inside the fixed area. The new bank number is taken from the two lowest address bits of that write. The data bus plays no part, so it is not an input of the block. Reads of the trigger addresses behave like any other fixed-area read.

The bus interface is plain:
- `cpu_req` marks a bus cycle.
- `cpu_we` marks that cycle as a write.
- `rom_addr` and `rom_ce_n` are combinational from the current address and the registered bank.
- There is no back-pressure. Every cycle is complete in one clock.
- A bank write takes effect at the clock edge that ends the write cycle.

Top module: `rom_bank_mapper`

## Requirements
- R1: `rom_ce_n` is 0 exactly when `cpu_req` is 1 and `cpu_addr[20]` is 0. It is 1 whenever `cpu_addr[20]` is 1 or `cpu_req` is 0.
- R2: For a fixed-area access (`cpu_addr[20:19]` = 00), `rom_addr` equals `{2'b00, cpu_addr[18:0]}`.
- R3: For a window access (`cpu_addr[20:19]` = 01), `rom_addr` equals `{bank, cpu_addr[18:0]}`, where `bank` is the 2-bit bank currently selected.
- R4: After reset the selected bank is 0, so a window access shows the same ROM bytes as the fixed area.
- R5: A cycle with `cpu_req`=1, `cpu_we`=1 and `cpu_addr` = 0x001FF0+x (x in 0..3) sets the bank to x at that clock edge. Every access in a later cycle uses bank x.
- R6: A write to a trigger address is itself mapped as a fixed-area access.
- R7: A read (`cpu_we`=0) of a trigger address leaves the bank unchanged.
- R8: The bank stays unchanged after each of these:
  - a write to any non-trigger address in the ROM region;
  - a write with `cpu_addr[20]`=1, even when its low bits match a trigger;
  - a write strobe while `cpu_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_req | input | 1 | Bus cycle active this clock |
| cpu_we | input | 1 | Cycle is a write |
| cpu_addr | input | 21 | Physical address |
| rom_addr | output | 21 | Address presented to the 2 MB ROM |
| rom_ce_n | output | 1 | ROM chip enable, active low |

## Verification
The bench builds the block with its default parameters:
- a 21-bit address bus;
- a 19-bit window offset;
- a 2-bit bank field;
- the trigger base at 0x001FF0.

With these values all four banks and all four trigger addresses can be reached in a short run. The random mix places many trigger writes, trigger reads and near-miss writes next to window reads. The near misses include trigger low bits with bit 20 set, a write without a request, and the neighbouring addresses 0x001FF4 and 0x081FF1. Each bank change is therefore observed at the ROM address pins on the very next window access.

// File: rtl/rbm_pkg.sv
package rbm_pkg;
  typedef enum logic [1:0] {
    RGN_FIXED  = 2'd0,
    RGN_WINDOW = 2'd1,
    RGN_OUTSIDE = 2'd2
  } region_e;
endpackage

// File: rtl/rbm_decode.sv
module rbm_decode
  import rbm_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int OFF_W  = 19,
  parameter int BANK_W = 2,
  parameter logic [ADDR_W-1:0] TRIG_BASE = 21'h001FF0
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output logic              trig_hit,
  output logic [BANK_W-1:0] trig_idx
);
  localparam int SLOTS = 1 << BANK_W;

  logic [SLOTS-1:0] slot_hit;

  // one comparator per trigger address
  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    localparam logic [ADDR_W-1:0] SLOT_ADDR = TRIG_BASE + ADDR_W'(g);
    assign slot_hit[g] = (addr == SLOT_ADDR);
  end

  always_comb begin
    trig_idx = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (slot_hit[i]) trig_idx = BANK_W'(i);
    end
  end

  assign trig_hit = |slot_hit;

  always_comb begin
    if (addr[ADDR_W-1])   region = RGN_OUTSIDE;
    else if (addr[OFF_W]) region = RGN_WINDOW;
    else                  region = RGN_FIXED;
  end
endmodule

// File: rtl/rbm_bank_reg.sv
module rbm_bank_reg #(
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BANK_W-1:0] d,
  output logic [BANK_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/rbm_compose.sv
module rbm_compose
  import rbm_pkg::*;
#(
  parameter int OFF_W  = 19,
  parameter int BANK_W = 2
) (
  input  logic                    req,
  input  region_e                 region,
  input  logic [BANK_W-1:0]       bank,
  input  logic [OFF_W-1:0]        offset,
  output logic [OFF_W+BANK_W-1:0] rom_addr,
  output logic                    rom_ce_n
);
  always_comb begin
    unique case (region)
      RGN_WINDOW: rom_addr = {bank, offset};
      default:    rom_addr = {{BANK_W{1'b0}}, offset};
    endcase
    rom_ce_n = !(req && (region != RGN_OUTSIDE));
  end
endmodule

// File: rtl/rom_bank_mapper.sv
module rom_bank_mapper
  import rbm_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int OFF_W  = 19,
  parameter int BANK_W = 2,
  parameter logic [ADDR_W-1:0] TRIG_BASE = 21'h001FF0,
  localparam int ROM_AW = OFF_W + BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              rom_ce_n
);
  region_e           region;
  logic              trig_hit;
  logic [BANK_W-1:0] trig_idx;
  logic [BANK_W-1:0] bank_q;
  logic              bank_load;

  rbm_decode #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .BANK_W(BANK_W), .TRIG_BASE(TRIG_BASE)
  ) dec_i (
    .addr(cpu_addr), .region(region), .trig_hit(trig_hit), .trig_idx(trig_idx)
  );

  assign bank_load = cpu_req && cpu_we && trig_hit;

  rbm_bank_reg #(.BANK_W(BANK_W)) bank_i (
    .clk(clk), .rst_n(rst_n), .load(bank_load), .d(trig_idx), .q(bank_q)
  );

  rbm_compose #(.OFF_W(OFF_W), .BANK_W(BANK_W)) comp_i (
    .req(cpu_req), .region(region), .bank(bank_q),
    .offset(cpu_addr[OFF_W-1:0]), .rom_addr(rom_addr), .rom_ce_n(rom_ce_n)
  );
endmodule

// File: rtl/rbm_checker.sv
module rbm_checker #(
  parameter int ADDR_W = 21,
  parameter int OFF_W  = 19,
  parameter int BANK_W = 2,
  parameter logic [ADDR_W-1:0] TRIG_BASE = 21'h001FF0
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cpu_req,
  input logic                    cpu_we,
  input logic [ADDR_W-1:0]       cpu_addr,
  input logic [OFF_W+BANK_W-1:0] rom_addr,
  input logic                    rom_ce_n,
  input logic [BANK_W-1:0]       bank_q
);
  logic is_trig;
  assign is_trig = cpu_addr[ADDR_W-1:BANK_W] == TRIG_BASE[ADDR_W-1:BANK_W];

  p_ce_off_outside_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[ADDR_W-1] || !cpu_req) |-> rom_ce_n);

  p_ce_on_region_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !cpu_addr[ADDR_W-1]) |-> !rom_ce_n);

  p_fixed_map_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_addr[ADDR_W-1:OFF_W] == 2'b00) |->
      rom_addr == {{BANK_W{1'b0}}, cpu_addr[OFF_W-1:0]});

  p_window_map_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_addr[ADDR_W-1:OFF_W] == 2'b01) |->
      (rom_addr[OFF_W+BANK_W-1:OFF_W] == bank_q &&
       rom_addr[OFF_W-1:0] == cpu_addr[OFF_W-1:0]));

  p_reset_bank_r4: assert property (@(posedge clk)
    $rose(rst_n) |-> bank_q == '0);

  p_bank_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_we && is_trig) |=> bank_q == $past(cpu_addr[BANK_W-1:0]));

  p_read_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !cpu_we) |=> $stable(bank_q));

  p_other_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_req || !is_trig) |=> $stable(bank_q));
endmodule

bind rom_bank_mapper rbm_checker #(
  .ADDR_W(ADDR_W), .OFF_W(OFF_W), .BANK_W(BANK_W), .TRIG_BASE(TRIG_BASE)
) chk_i (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
  .cpu_addr(cpu_addr), .rom_addr(rom_addr), .rom_ce_n(rom_ce_n), .bank_q(bank_q)
);

// File: tb/rom_bank_mapper_tb_top.sv
`timescale 1ns/1ps
module rom_bank_mapper_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0;
  logic        cpu_we = 1'b0;
  logic [20:0] cpu_addr = '0;
  logic [20:0] rom_addr;
  logic        rom_ce_n;

  int checks = 0;
  int failures = 0;
  logic [1:0] bank_m = 2'd0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rom_bank_mapper dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .rom_addr(rom_addr), .rom_ce_n(rom_ce_n)
  );

  function automatic logic [20:0] exp_rom(logic [20:0] a, logic [1:0] b);
    return a[19] ? {b, a[18:0]} : {2'b00, a[18:0]};
  endfunction

  function automatic bit is_trig(logic [20:0] a);
    return a[20:2] == 19'h007FC;
  endfunction

  task automatic chk(bit ok, string tag, logic [20:0] act, logic [20:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one bus cycle: drive after negedge, check before posedge, update model at posedge
  task automatic step(bit req, bit we, logic [20:0] a, string tag);
    @(negedge clk);
    cpu_req = req; cpu_we = we; cpu_addr = a;
    #1;
    chk(rom_ce_n == !(req && !a[20]), "R1", 21'(rom_ce_n), 21'(!(req && !a[20])));
    if (req && !a[20]) begin
      string t;
      t = (tag != "") ? tag : (is_trig(a) ? "R6" : (a[19] ? "R3" : "R2"));
      chk(rom_addr == exp_rom(a, bank_m), t, rom_addr, exp_rom(a, bank_m));
    end
    @(posedge clk);
    if (req && we && is_trig(a)) bank_m = a[1:0];
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    #1;
    chk(rom_ce_n == 1'b1, "R1", 21'(rom_ce_n), 21'd1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R4: window shows bank 0 after reset
    step(1, 0, 21'h080123, "R4");
    step(1, 0, 21'h0FFFFF, "R4");
    // R5 + R6: select bank 2, then read the window
    step(1, 1, 21'h001FF2, "R6");
    step(1, 0, 21'h080010, "R5");
    // R7: reading a trigger leaves the bank alone
    step(1, 0, 21'h001FF1, "R6");
    step(1, 0, 21'h0C0010, "R7");
    // R8: several near-miss writes
    step(1, 1, 21'h101FF3, "");
    step(1, 0, 21'h080020, "R8");
    step(0, 1, 21'h001FF0, "");
    step(1, 0, 21'h080030, "R8");
    step(1, 1, 21'h001FF4, "");
    step(1, 0, 21'h080040, "R8");
    step(1, 1, 21'h081FF1, "");
    step(1, 0, 21'h080050, "R8");
    // R5: each bank, back to back
    for (int x = 0; x < 4; x++) begin
      step(1, 1, 21'h001FF0 + 21'(3 - x), "R6");
      step(1, 0, 21'h0ABCDE, "R5");
    end
    step(1, 1, 21'h001FF1, "R6");
    step(1, 1, 21'h001FF3, "R6");
    step(1, 0, 21'h0FFFF0, "R5");

    // random mix
    for (int n = 0; n < 4000; n++) begin
      int k;
      logic [20:0] a;
      k = int'($urandom % 10);
      a = 21'($urandom);
      case (k)
        0, 1: step(1, 1, 21'h001FF0 + 21'($urandom % 4), "");
        2:    step(1, 0, 21'h001FF0 + 21'($urandom % 4), "");
        3:    step(1, 1, 21'h101FF0 + 21'($urandom % 4), "");
        4:    step(0, 1, 21'h001FF0 + 21'($urandom % 4), "");
        5, 6: step(1, 0, {2'b01, a[18:0]}, "");
        default: step(1'($urandom), 1'($urandom), a, "");
      endcase
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule